// File: doc/BRIEF.md
# System Address Decoder with Boot ROM, Banked RAMs and I/O Windows

This block is the memory side of a small processor. It has two address ports. The instruction-fetch port reads either a fixed boot ROM or an instruction RAM. The data port reads and writes a data RAM, a stack RAM and the instruction RAM. It also reaches four I/O device windows of 1 KB each.

Each port decodes its 32-bit byte address into one target region. Inside the 3 KB regions, address bits [11:10] pick one of three 256-word banks and bits [9:2] pick the word. Reads are combinational, so the read data follows the address in the same cycle. A write lands at the next rising clock edge. The 2-bit write control is sent only to the addressed target. For an I/O device it goes out unchanged on that device's write-enable pins, and every other device gets zero.

The instruction RAM accepts data-port accesses only while the fetch address is inside the boot ROM. This lets boot code fill the RAM, and code that runs from the RAM cannot overwrite itself. A synchronous active-low reset blocks every write while it is held.

Top module: `sysmem_decoder`

## Requirements
- R1: An instruction address in 0x00000000..0x000003FF returns the boot ROM word for index i = addr[9:2], defined as {8'hC0, i, ~i, i ^ 8'h5A}.
- R2: An instruction address in 0x00400000..0x00400BFF returns the instruction RAM word at bank addr[11:10] and word addr[9:2], in the same cycle.
- R3: A data address in 0x10000000..0x10000BFF (data RAM, bank addr[11:10]) or in 0x7FFF0000..0x7FFF03FF (stack RAM) reads the stored word in the same cycle. A write there becomes visible from the next cycle.
- R4: Write control 2'b00 writes nothing. 2'b01 writes wr_data[7:0] into byte lane addr[1:0]. 2'b11 writes wr_data[15:0] into the lower half when addr[1]=0 and into the upper half when addr[1]=1. 2'b10 writes the whole word. Lanes that are not selected keep their contents.
- R5: Data accesses to 0x00400000..0x00400BFF reach the instruction RAM only while the instruction address lies in the boot ROM region. Otherwise the read returns zero and the write is dropped.
- R6: A data address in 0x80000000..0x80000FFF selects I/O device k = addr[11:10]. The data read returns io<k>_rdata, and io<k>_we carries wr_ctl.
- R7: Every I/O device that is not addressed sees write enable 2'b00.
- R8: An address outside every region returns zero on its port, and a data write to it changes no storage and raises no I/O write enable. This includes bank value 3 of a 3 KB region and ROM addresses on the data port.
- R9: While rst_n is low, no storage is written and all I/O write enables are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; blocks writes |
| wr_ctl | input | 2 | Write control: 00 none, 01 byte, 10 word, 11 halfword |
| ifetch_addr | input | 32 | Instruction byte address |
| data_addr | input | 32 | Data byte address |
| wr_data | input | 32 | Write data, right-aligned for byte and halfword writes |
| io0_rdata | input | 32 | Read data from I/O device 0 |
| io1_rdata | input | 32 | Read data from I/O device 1 |
| io2_rdata | input | 32 | Read data from I/O device 2 |
| io3_rdata | input | 32 | Read data from I/O device 3 |
| instr_out | output | 32 | Fetched instruction |
| data_rdata | output | 32 | Data read result |
| io0_we | output | 2 | Write enable for I/O device 0 |
| io1_we | output | 2 | Write enable for I/O device 1 |
| io2_we | output | 2 | Write enable for I/O device 2 |
| io3_we | output | 2 | Write enable for I/O device 3 |

## Verification
The assertions assume that wr_ctl, both addresses and wr_data are stable over each whole cycle and settle before the rising edge. They also assume that rst_n is held low from time zero until the first edges have passed, so the write gates start closed. The bench changes every input only on the falling edge and holds reset low at start. Before it checks any read, it fills every RAM word with word writes, so no read compares storage that was never written. Random addresses come from a per-region draw that also covers the bank-3 holes and arbitrary 32-bit values. The instruction port is steered between ROM, RAM and unmapped space so that the instruction RAM lock is exercised both open and closed.

// File: rtl/sysmem_pkg.sv
// Shared constants, region codes and write-lane helpers for the system
// address decoder. Assumes a 32-bit little-endian byte-addressed bus.
package sysmem_pkg;

    localparam int unsigned DW    = 32;
    localparam int unsigned NL    = DW / 8;
    localparam int unsigned WORDS = 256;
    localparam int unsigned WIDX  = $clog2(WORDS);
    localparam int unsigned BANKS = 3;
    localparam int unsigned NIO   = 4;

    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_ROM   = 3'd1,
        RG_IRAM  = 3'd2,
        RG_DRAM  = 3'd3,
        RG_STACK = 3'd4,
        RG_IO    = 3'd5
    } region_e;

    typedef struct packed {
        region_e         region;
        logic [1:0]      bank;
        logic [WIDX-1:0] word;
    } decode_t;

    // Boot ROM contents, computed from the word index.
    function automatic logic [DW-1:0] boot_word(input logic [WIDX-1:0] idx);
        return {8'hC0, idx, ~idx, idx ^ 8'h5A};
    endfunction

    // Byte lanes touched by a write code at a given byte offset.
    function automatic logic [NL-1:0] lane_mask(input logic [1:0] ctl,
                                                input logic [1:0] ofs);
        case (ctl)
            2'b01:   return NL'(1) << ofs;
            2'b11:   return ofs[1] ? 4'b1100 : 4'b0011;
            2'b10:   return '1;
            default: return '0;
        endcase
    endfunction

    // Replicate right-aligned write data across the lanes.
    function automatic logic [DW-1:0] lane_data(input logic [1:0] ctl,
                                                input logic [DW-1:0] d);
        case (ctl)
            2'b01:   return {NL{d[7:0]}};
            2'b11:   return {(NL/2){d[15:0]}};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/sysmem_addr_decode.sv
// Maps a word address (byte address without bits [1:0]) to a region,
// a bank number and a word index. Purely combinational. Assumes the
// base parameters are aligned to 4 KB (RAM and I/O) or 1 KB (stack).
module sysmem_addr_decode
    import sysmem_pkg::*;
#(
    parameter logic [31:0] IRAM_BASE  = 32'h0040_0000,
    parameter logic [31:0] DRAM_BASE  = 32'h1000_0000,
    parameter logic [31:0] STACK_BASE = 32'h7FFF_0000,
    parameter logic [31:0] IO_BASE    = 32'h8000_0000
) (
    input  logic [31:2] word_addr,
    output decode_t     dec
);

    logic hole;

    // Bank value 3 lies outside every 3 KB region.
    assign hole = (word_addr[11:10] == 2'b11);

    // Region select from the upper address bits.
    always_comb begin
        dec.bank   = word_addr[11:10];
        dec.word   = word_addr[WIDX+1:2];
        dec.region = RG_NONE;
        if (word_addr[31:10] == '0)
            dec.region = RG_ROM;
        else if (word_addr[31:12] == IRAM_BASE[31:12] && !hole)
            dec.region = RG_IRAM;
        else if (word_addr[31:12] == DRAM_BASE[31:12] && !hole)
            dec.region = RG_DRAM;
        else if (word_addr[31:10] == STACK_BASE[31:10])
            dec.region = RG_STACK;
        else if (word_addr[31:12] == IO_BASE[31:12])
            dec.region = RG_IO;
    end

endmodule

// File: rtl/sysmem_ram_bank.sv
// One RAM bank with a byte-lane write port and NRD combinational read
// ports. Assumes the write enable and lane mask settle before the edge.
module sysmem_ram_bank #(
    parameter  int DW    = 32,
    parameter  int DEPTH = 256,
    parameter  int NRD   = 1,
    localparam int IW    = $clog2(DEPTH),
    localparam int NL    = DW / 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [NL-1:0]           lane_en,
    input  logic [IW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][IW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Commit the enabled byte lanes on the rising edge.
    always_ff @(posedge clk) begin : p_write
        if (we) begin
            for (int l = 0; l < NL; l++) begin
                if (lane_en[l]) mem[waddr][l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

    for (genvar l = 0; l < NL; l++) begin : g_chk
        AST_LANE_COMMIT: assert property (@(posedge clk) (we && lane_en[l]) |=> (mem[$past(waddr)][l*8 +: 8] == $past(wdata[l*8 +: 8]))) else $error("lane not committed"); // R4
    end

endmodule

// File: rtl/sysmem_decoder.sv
// System address decoder: boot ROM and instruction RAM on the fetch port,
// data RAM, stack RAM, instruction RAM and four I/O windows on the data
// port. Reads are combinational; writes land on the rising edge and are
// blocked while rst_n is low. Assumes inputs are stable across a cycle.
module sysmem_decoder
    import sysmem_pkg::*;
#(
    parameter logic [31:0] IRAM_BASE  = 32'h0040_0000,
    parameter logic [31:0] DRAM_BASE  = 32'h1000_0000,
    parameter logic [31:0] STACK_BASE = 32'h7FFF_0000,
    parameter logic [31:0] IO_BASE    = 32'h8000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  wr_ctl,
    input  logic [31:0] ifetch_addr,
    input  logic [31:0] data_addr,
    input  logic [31:0] wr_data,
    input  logic [31:0] io0_rdata,
    input  logic [31:0] io1_rdata,
    input  logic [31:0] io2_rdata,
    input  logic [31:0] io3_rdata,
    output logic [31:0] instr_out,
    output logic [31:0] data_rdata,
    output logic [1:0]  io0_we,
    output logic [1:0]  io1_we,
    output logic [1:0]  io2_we,
    output logic [1:0]  io3_we
);

    decode_t                  idec;
    decode_t                  ddec;
    logic                     rom_exec;
    logic                     wr_go;
    logic [NL-1:0]            lanes;
    logic [DW-1:0]            wword;
    logic [BANKS-1:0]         iram_we;
    logic [BANKS-1:0]         dram_we;
    logic                     stack_we;
    logic [1:0][DW-1:0]       iram_rd [BANKS];
    logic [0:0][DW-1:0]       dram_rd [BANKS];
    logic [0:0][DW-1:0]       stack_rd;
    logic [DW-1:0]            iram_i;
    logic [DW-1:0]            iram_d;
    logic [DW-1:0]            dram_d;
    logic [NIO-1:0][DW-1:0]   io_rd;
    logic [NIO-1:0][1:0]      io_we_v;
    logic [NIO-1:0]           io_hit;
    logic                     unused_fetch_lsb;

    assign unused_fetch_lsb = ^ifetch_addr[1:0];

    sysmem_addr_decode #(
        .IRAM_BASE(IRAM_BASE), .DRAM_BASE(DRAM_BASE),
        .STACK_BASE(STACK_BASE), .IO_BASE(IO_BASE)
    ) u_idec (
        .word_addr(ifetch_addr[31:2]),
        .dec      (idec)
    );

    sysmem_addr_decode #(
        .IRAM_BASE(IRAM_BASE), .DRAM_BASE(DRAM_BASE),
        .STACK_BASE(STACK_BASE), .IO_BASE(IO_BASE)
    ) u_ddec (
        .word_addr(data_addr[31:2]),
        .dec      (ddec)
    );

    assign rom_exec = (idec.region == RG_ROM);
    assign wr_go    = rst_n && (wr_ctl != 2'b00);
    assign lanes    = lane_mask(wr_ctl, data_addr[1:0]);
    assign wword    = lane_data(wr_ctl, wr_data);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign iram_we[b] = wr_go && rom_exec && (ddec.region == RG_IRAM)
                            && (ddec.bank == 2'(b));
        assign dram_we[b] = wr_go && (ddec.region == RG_DRAM)
                            && (ddec.bank == 2'(b));

        sysmem_ram_bank #(.DW(DW), .DEPTH(WORDS), .NRD(2)) u_iram (
            .clk    (clk),
            .we     (iram_we[b]),
            .lane_en(lanes),
            .waddr  (ddec.word),
            .wdata  (wword),
            .raddr  ({ddec.word, idec.word}),
            .rdata  (iram_rd[b])
        );

        sysmem_ram_bank #(.DW(DW), .DEPTH(WORDS), .NRD(1)) u_dram (
            .clk    (clk),
            .we     (dram_we[b]),
            .lane_en(lanes),
            .waddr  (ddec.word),
            .wdata  (wword),
            .raddr  (ddec.word),
            .rdata  (dram_rd[b])
        );
    end

    assign stack_we = wr_go && (ddec.region == RG_STACK);

    sysmem_ram_bank #(.DW(DW), .DEPTH(WORDS), .NRD(1)) u_stack (
        .clk    (clk),
        .we     (stack_we),
        .lane_en(lanes),
        .waddr  (ddec.word),
        .wdata  (wword),
        .raddr  (ddec.word),
        .rdata  (stack_rd)
    );

    // Pick the addressed bank's read data for each port.
    always_comb begin
        iram_i = '0;
        iram_d = '0;
        dram_d = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (idec.bank == 2'(b)) iram_i = iram_rd[b][0];
            if (ddec.bank == 2'(b)) begin
                iram_d = iram_rd[b][1];
                dram_d = dram_rd[b][0];
            end
        end
    end

    assign io_rd = {io3_rdata, io2_rdata, io1_rdata, io0_rdata};

    for (genvar k = 0; k < NIO; k++) begin : g_io
        assign io_we_v[k] = (wr_go && (ddec.region == RG_IO) && (ddec.bank == 2'(k)))
                            ? wr_ctl : 2'b00;
        assign io_hit[k]  = |io_we_v[k];

        AST_IO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) io_hit[k] |-> (data_addr[31:12] == IO_BASE[31:12] && data_addr[11:10] == 2'(k))) else $error("io enable misrouted"); // R6
    end

    assign io0_we = io_we_v[0];
    assign io1_we = io_we_v[1];
    assign io2_we = io_we_v[2];
    assign io3_we = io_we_v[3];

    // Instruction port result by fetch region.
    always_comb begin
        case (idec.region)
            RG_ROM:  instr_out = boot_word(idec.word);
            RG_IRAM: instr_out = iram_i;
            default: instr_out = '0;
        endcase
    end

    // Data port result by data region; instruction RAM gated by fetch region.
    always_comb begin
        case (ddec.region)
            RG_IRAM:  data_rdata = rom_exec ? iram_d : '0;
            RG_DRAM:  data_rdata = dram_d;
            RG_STACK: data_rdata = stack_rd[0];
            RG_IO:    data_rdata = io_rd[ddec.bank];
            default:  data_rdata = '0;
        endcase
    end

    AST_IRAM_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (idec.region != RG_ROM) |-> (iram_we == '0)) else $error("iram written outside boot"); // R5
    AST_IO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $countones(io_hit) <= 1) else $error("several io enables"); // R7
    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (ddec.region == RG_NONE) |-> (data_rdata == '0 && io_hit == '0 && iram_we == '0 && dram_we == '0 && !stack_we)) else $error("unmapped access active"); // R8
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (io_hit == '0 && iram_we == '0 && dram_we == '0 && !stack_we)) else $error("write during reset"); // R9

endmodule

// File: tb/sysmem_decoder_test.sv
// Self-checking bench: reference model of all storage, directed corner
// cases, then seeded random traffic. Inputs change on the falling edge.
module sysmem_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_ctl = 2'b00;
    logic [31:0] ifetch_addr = '0;
    logic [31:0] data_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] io_val [4];
    logic [31:0] instr_out, data_rdata;
    logic [1:0]  io0_we, io1_we, io2_we, io3_we;

    logic [31:0] m_iram [3][256];
    logic [31:0] m_dram [3][256];
    logic [31:0] m_stack [256];

    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    sysmem_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl),
        .ifetch_addr(ifetch_addr), .data_addr(data_addr), .wr_data(wr_data),
        .io0_rdata(io_val[0]), .io1_rdata(io_val[1]),
        .io2_rdata(io_val[2]), .io3_rdata(io_val[3]),
        .instr_out(instr_out), .data_rdata(data_rdata),
        .io0_we(io0_we), .io1_we(io1_we), .io2_we(io2_we), .io3_we(io3_we)
    );

    // 0 none, 1 rom, 2 iram, 3 dram, 4 stack, 5 io
    function automatic int cls(input logic [31:0] a);
        if (a <= 32'h0000_03FF) return 1;
        if (a >= 32'h0040_0000 && a <= 32'h0040_0BFF) return 2;
        if (a >= 32'h1000_0000 && a <= 32'h1000_0BFF) return 3;
        if (a >= 32'h7FFF_0000 && a <= 32'h7FFF_03FF) return 4;
        if (a >= 32'h8000_0000 && a <= 32'h8000_0FFF) return 5;
        return 0;
    endfunction

    function automatic logic [31:0] exp_instr(input logic [31:0] ia);
        logic [7:0] i = ia[9:2];
        case (cls(ia))
            1: return {8'hC0, i, ~i, i ^ 8'h5A};
            2: return m_iram[ia[11:10]][ia[9:2]];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] da, input logic [31:0] ia);
        case (cls(da))
            2: return (cls(ia) == 1) ? m_iram[da[11:10]][da[9:2]] : 32'h0;
            3: return m_dram[da[11:10]][da[9:2]];
            4: return m_stack[da[9:2]];
            5: return io_val[da[11:10]];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [1:0] exp_we(input int k, input logic [31:0] da,
                                          input logic [1:0] ctl, input logic rv);
        return (rv && cls(da) == 5 && int'(da[11:10]) == k) ? ctl : 2'b00;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] da,
                                          input logic [1:0] ctl, input logic [31:0] wd);
        logic [31:0] w = old;
        case (ctl)
            2'b01: w[da[1:0]*8 +: 8] = wd[7:0];
            2'b11: if (da[1]) w[31:16] = wd[15:0]; else w[15:0] = wd[15:0];
            2'b10: w = wd;
            default: ;
        endcase
        return w;
    endfunction

    function automatic string tag_instr(input logic [31:0] ia);
        case (cls(ia))
            1: return "R1";
            2: return "R2";
            default: return "R8";
        endcase
    endfunction

    function automatic string tag_data(input logic [31:0] da);
        case (cls(da))
            2: return "R5";
            3, 4: return "R3";
            5: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply_write(input logic [31:0] ia, input logic [31:0] da,
                               input logic [1:0] ctl, input logic [31:0] wd);
        if (ctl == 2'b00) return;
        case (cls(da))
            2: if (cls(ia) == 1)
                   m_iram[da[11:10]][da[9:2]] = merge(m_iram[da[11:10]][da[9:2]], da, ctl, wd);
            3: m_dram[da[11:10]][da[9:2]] = merge(m_dram[da[11:10]][da[9:2]], da, ctl, wd);
            4: m_stack[da[9:2]] = merge(m_stack[da[9:2]], da, ctl, wd);
            default: ;
        endcase
    endtask

    // One cycle: drive on the falling edge, check after settling; the write
    // (if any) lands on the following rising edge.
    task automatic step(input logic [31:0] ia, input logic [31:0] da, input logic [1:0] ctl,
                        input logic [31:0] wd, input logic rv, input bit rd_chk, input string dtag);
        logic [1:0] we_act [4];
        @(negedge clk);
        rst_n = rv; ifetch_addr = ia; data_addr = da; wr_ctl = ctl; wr_data = wd;
        #1;
        we_act[0] = io0_we; we_act[1] = io1_we; we_act[2] = io2_we; we_act[3] = io3_we;
        if (rd_chk) begin
            chk(tag_instr(ia), instr_out, exp_instr(ia));
            chk(dtag != "" ? dtag : tag_data(da), data_rdata, exp_data(da, ia));
        end
        for (int k = 0; k < 4; k++)
            chk(!rv ? "R9" : (exp_we(k, da, ctl, rv) != 2'b00 ? "R6" : "R7"),
                {30'd0, we_act[k]}, {30'd0, exp_we(k, da, ctl, rv)});
        if (rv) apply_write(ia, da, ctl, wd);
    endtask

    function automatic logic [31:0] rand_daddr();
        case ($urandom % 8)
            0: return $urandom % 32'h400;
            1: return 32'h0040_0000 + ($urandom % 32'hC00);
            2: return 32'h1000_0000 + ($urandom % 32'hC00);
            3: return 32'h7FFF_0000 + ($urandom % 32'h400);
            4: return 32'h8000_0000 + ($urandom % 32'h1000);
            5: return 32'h1000_0C00 + ($urandom % 32'h400);
            6: return $urandom;
            default: return 32'h7FFF_0400 + ($urandom % 32'h400);
        endcase
    endfunction

    function automatic logic [31:0] rand_iaddr();
        int r = $urandom % 10;
        if (r < 5) return $urandom % 32'h400;
        if (r < 9) return 32'h0040_0000 + ($urandom % 32'hC00);
        return $urandom;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] keep;
        void'($urandom(32'd20061));
        for (int k = 0; k < 4; k++) io_val[k] = 32'hA000_0000 + 32'(k);

        // R9: reset held, writes attempted on I/O windows
        for (int k = 0; k < 4; k++)
            step(32'h0, 32'h8000_0000 + 32'(k * 1024), 2'b10, 32'h1, 1'b0, 1'b0, "R9");

        // Fill every RAM word with word writes while executing from ROM
        for (int b = 0; b < 3; b++)
            for (int w = 0; w < 256; w++) begin
                step(32'h0, 32'h0040_0000 + 32'(b * 1024 + w * 4), 2'b10, $urandom, 1'b1, 1'b0, "");
                step(32'h0, 32'h1000_0000 + 32'(b * 1024 + w * 4), 2'b10, $urandom, 1'b1, 1'b0, "");
            end
        for (int w = 0; w < 256; w++)
            step(32'h0, 32'h7FFF_0000 + 32'(w * 4), 2'b10, $urandom, 1'b1, 1'b0, "");

        // R9: write during reset must not change storage
        keep = m_dram[1][5];
        step(32'h0, 32'h1000_0414, 2'b10, ~keep, 1'b0, 1'b0, "R9");
        step(32'h0, 32'h1000_0414, 2'b00, 32'h0, 1'b1, 1'b1, "R9");

        // R1: ROM boundaries
        step(32'h0000_0000, 32'h0, 2'b00, 32'h0, 1'b1, 1'b1, "R8");
        step(32'h0000_03FC, 32'h0, 2'b00, 32'h0, 1'b1, 1'b1, "R8");
        // R2: first and last instruction RAM words
        step(32'h0040_0000, 32'h1000_0000, 2'b00, 32'h0, 1'b1, 1'b1, "");
        step(32'h0040_0BFC, 32'h1000_0BFC, 2'b00, 32'h0, 1'b1, 1'b1, "");

        // R4: every byte lane, both halves, then read back
        for (int l = 0; l < 4; l++) begin
            step(32'h0, 32'h1000_0800 + 32'(l), 2'b01, 32'h5A5A_5A00 + 32'(l), 1'b1, 1'b1, "");
            step(32'h0, 32'h1000_0800, 2'b00, 32'h0, 1'b1, 1'b1, "R4");
        end
        step(32'h0, 32'h7FFF_0010, 2'b11, 32'hFFFF_1234, 1'b1, 1'b1, "");
        step(32'h0, 32'h7FFF_0012, 2'b11, 32'h0000_ABCD, 1'b1, 1'b1, "R4");
        step(32'h0, 32'h7FFF_0010, 2'b00, 32'h0, 1'b1, 1'b1, "R4");

        // R5: data write to instruction RAM while executing from RAM is dropped
        step(32'h0040_0010, 32'h0040_0020, 2'b10, 32'hDEAD_BEEF, 1'b1, 1'b1, "R5");
        step(32'h0000_0004, 32'h0040_0020, 2'b00, 32'h0, 1'b1, 1'b1, "R5");
        step(32'h0000_0004, 32'h0040_0020, 2'b10, 32'h1357_9BDF, 1'b1, 1'b1, "R5");
        step(32'h0000_0004, 32'h0040_0020, 2'b00, 32'h0, 1'b1, 1'b1, "R5");

        // R8: holes and unmapped space
        step(32'h0040_0C00, 32'h1000_0C00, 2'b10, 32'hFFFF_FFFF, 1'b1, 1'b1, "R8");
        step(32'h0, 32'h0040_0C04, 2'b10, 32'hFFFF_FFFF, 1'b1, 1'b1, "R8");
        step(32'h0, 32'h7FFF_0400, 2'b10, 32'hFFFF_FFFF, 1'b1, 1'b1, "R8");
        step(32'h0, 32'h8000_1000, 2'b01, 32'hFFFF_FFFF, 1'b1, 1'b1, "R8");
        step(32'h0, 32'h1000_0000, 2'b00, 32'h0, 1'b1, 1'b1, "R8");

        // R6/R7: each I/O window with every write code
        for (int k = 0; k < 4; k++)
            for (int c = 0; c < 4; c++)
                step(32'h0, 32'h8000_0000 + 32'(k * 1024 + c * 4), 2'(c), 32'h0, 1'b1, 1'b1, "R6");

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < 4; k++) io_val[k] = $urandom;
            step(rand_iaddr(), rand_daddr(), 2'($urandom), $urandom, 1'b1, 1'b1, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule